// File: doc/BRIEF.md
# Eager Handshake Fork

This block takes one stream of tokens under a valid/ready handshake and offers each token to several output streams at once. Every output may take the token in its own cycle. Once an output has taken the current token, the block remembers this and stops offering that token to it, so a slow output never causes a fast one to see the token twice. The input is acknowledged only when every output has the token.

The block is a pure control element between a single producer and a parameterised number of consumers. It has no data storage: every output data bus is the input data bus itself, which is safe because the producer keeps its data steady until the acknowledge. Valid and ready pass through combinationally. The only state is one "already taken" flag per output.

Top module: `hs_eager_fork`

## Requirements
- R1: A synchronous active-high reset clears every taken flag, so the first cycle after reset with the input valid offers the token on every output.
- R2: Output i presents valid exactly when the input is valid and output i has not yet taken the current token.
- R3: Every output data bus equals the input data bus in every cycle.
- R4: The input ready is high exactly when, for every output, either that output's valid and ready are both high in this cycle or that output took the current token in an earlier cycle.
- R5: An output that completes a handshake in a cycle where the input is not acknowledged drops its valid from the next cycle until the input is acknowledged, so it never sees the same token twice.
- R6: When every output accepts in the same cycle, the input is acknowledged in that cycle and no taken flag is left set.
- R7: In the cycle after an input acknowledge, a new valid token is offered on every output.
- R8: While the input valid is low, every output valid and the input ready are low.
- R9: Under arbitrary per-output ready stalls, each output receives every acknowledged input token exactly once and in the order the input presented them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Producer holds a token |
| in_ready | output | 1 | Token acknowledged: all outputs have it |
| in_data | input | DATA_W | Token payload, held while in_valid and not in_ready |
| out_valid | output | NUM_OUT | Per-output token offer, bit i for output i |
| out_ready | input | NUM_OUT | Per-output acceptance, bit i for output i |
| out_data | output | NUM_OUT*DATA_W | Payload copies, output i at bits [i*DATA_W +: DATA_W] |

## Verification
The delicate cycle is one where an output completes its handshake and, at the same edge, the input is finally acknowledged: the taken flag of that output must not be set, while in any other cycle the same handshake must set it. The bench provokes both cases with a rotating single-ready pattern (last output completes the token), an all-ready pattern (every output completes together) and long runs of random per-output stalls. A behavioural model tracking which outputs already hold the current token predicts every valid and the input ready on every clock, and per-output receive counts are compared with the number of acknowledged tokens at the end.

// File: rtl/efork_pkg.sv
package efork_pkg;

  // Smallest meaningful number of fork outputs.
  localparam int unsigned MIN_LEGS = 2;

  // Per-output record of the current token.
  typedef enum logic {
    LEG_OPEN  = 1'b0,  // token still owed to this output
    LEG_TAKEN = 1'b1   // output already consumed the current token
  } leg_st_e;

endpackage

// File: rtl/efork_leg.sv
module efork_leg
  import efork_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic src_valid,
  input  logic src_ack,
  input  logic dst_ready,
  output logic dst_valid,
  output logic leg_done
);

  leg_st_e st_q;
  leg_st_e st_d;

  // Offer the token only while this output has not consumed it yet.
  assign dst_valid = src_valid && (st_q == LEG_OPEN);

  // Satisfied either by a handshake now or by one in an earlier cycle.
  assign leg_done = (dst_valid && dst_ready) || (st_q == LEG_TAKEN);

  // Remember consumption unless the input token retires at this edge.
  always_comb begin
    if (leg_done && !src_ack) st_d = LEG_TAKEN;
    else                      st_d = LEG_OPEN;
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= LEG_OPEN;
    else     st_q <= st_d;
  end

endmodule

// File: rtl/efork_ack.sv
module efork_ack #(
  parameter int unsigned NUM_OUT = 2
) (
  input  logic [NUM_OUT-1:0] done_vec,
  output logic               all_done
);

  assign all_done = &done_vec;

endmodule

// File: rtl/hs_eager_fork.sv
module hs_eager_fork
  import efork_pkg::*;
#(
  parameter int unsigned NUM_OUT = 4,
  parameter int unsigned DATA_W  = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [DATA_W-1:0]         in_data,
  output logic [NUM_OUT-1:0]        out_valid,
  input  logic [NUM_OUT-1:0]        out_ready,
  output logic [NUM_OUT*DATA_W-1:0] out_data
);

  // NUM_OUT is expected to be at least MIN_LEGS.
  localparam int unsigned BUS_W = NUM_OUT * DATA_W;

  logic [NUM_OUT-1:0] done_vec;
  logic               ack;

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_leg
    efork_leg u_leg (
      .clk       (clk),
      .rst       (rst),
      .src_valid (in_valid),
      .src_ack   (ack),
      .dst_ready (out_ready[g]),
      .dst_valid (out_valid[g]),
      .leg_done  (done_vec[g])
    );

    // Payload is forwarded; the producer holds it until acknowledged.
    assign out_data[g*DATA_W +: DATA_W] = in_data;
  end

  efork_ack #(.NUM_OUT(NUM_OUT)) u_ack (
    .done_vec (done_vec),
    .all_done (ack)
  );

  assign in_ready = ack;

  logic [BUS_W-1:0] unused_bus_w;
  assign unused_bus_w = out_data;

endmodule

// File: rtl/hs_eager_fork_chk.sv
module hs_eager_fork_chk #(
  parameter int unsigned NUM_OUT = 4,
  parameter int unsigned DATA_W  = 16
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      in_valid,
  input logic                      in_ready,
  input logic [DATA_W-1:0]         in_data,
  input logic [NUM_OUT-1:0]        out_valid,
  input logic [NUM_OUT-1:0]        out_ready,
  input logic [NUM_OUT*DATA_W-1:0] out_data
);

  // R8: no offer and no acknowledge without an input token
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> (out_valid == '0) && !in_ready);

  // R7: after an acknowledge, a fresh token is offered everywhere
  p_fresh_offer_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (!in_valid || (&out_valid)));

  // R1: first cycle out of reset offers on every output
  p_reset_open_r1: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && in_valid) |-> (&out_valid));

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_leg_chk
    // R5: a leg that took the token early is silent next cycle
    p_no_repeat_r5: assert property (@(posedge clk) disable iff (rst)
      (out_valid[g] && out_ready[g] && !in_ready) |=> !out_valid[g]);

    // R4: an acknowledge never leaves an offered output unaccepted
    p_ack_complete_r4: assert property (@(posedge clk) disable iff (rst)
      (in_ready && out_valid[g]) |-> out_ready[g]);

    // R3: every output carries the input payload
    p_data_copy_r3: assert property (@(posedge clk) disable iff (rst)
      out_data[g*DATA_W +: DATA_W] == in_data);
  end

endmodule

bind hs_eager_fork hs_eager_fork_chk #(.NUM_OUT(NUM_OUT), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/tb_hs_eager_fork.sv
`timescale 1ns/1ps
module tb_hs_eager_fork;

  localparam int NO = 3;
  localparam int DW = 8;

  logic               clk = 1'b0;
  logic               rst;
  logic               in_valid;
  logic               in_ready;
  logic [DW-1:0]      in_data;
  logic [NO-1:0]      out_valid;
  logic [NO-1:0]      out_ready;
  logic [NO*DW-1:0]   out_data;

  always #10 clk = ~clk;  // 50 MHz

  hs_eager_fork #(.NUM_OUT(NO), .DATA_W(DW)) dut (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  int  checks   = 0;
  int  failures = 0;
  bit  finished = 0;

  // Model state: which outputs already hold the current token.
  bit [NO-1:0] got;
  bit          src_has;
  logic [DW-1:0] cur;
  int          acked;
  int          rx_cnt [NO];
  bit          after_ack;
  bit          after_rst;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [NO-1:0] ready_pat(input int mode, input int cyc);
    logic [NO-1:0] r;
    case (mode)
      0: r = '1;
      1: r = NO'(1) << (cyc % NO);
      2: for (int i = 0; i < NO; i++) r[i] = ($urandom_range(0, 1) == 1);
      default: for (int i = 0; i < NO; i++) r[i] = ($urandom_range(0, 3) == 0);
    endcase
    return r;
  endfunction

  task automatic do_reset();
    rst       = 1'b1;
    out_ready = '0;
    in_valid  = src_has;
    repeat (2) @(negedge clk);
    rst       = 1'b0;
    got       = '0;
    after_rst = 1'b1;
    after_ack = 1'b0;
  endtask

  task automatic run_cycles(input int n, input int mode, input int gap_pct);
    for (int c = 0; c < n; c++) begin
      logic [NO-1:0] exp_v;
      logic [NO-1:0] hs;
      bit exp_rdy;
      string tag;
      @(negedge clk);
      if (!src_has && ($urandom_range(0, 99) >= gap_pct) && !(after_rst && mode == 99)) begin
        src_has = 1'b1;
        cur     = DW'($urandom_range(0, 255));
      end
      in_valid  = src_has;
      in_data   = cur;
      out_ready = ready_pat(mode, c);
      #1;
      for (int i = 0; i < NO; i++) begin
        exp_v[i] = in_valid && !got[i];
        if (!in_valid)      tag = "R8";
        else if (after_rst) tag = "R1";
        else if (got[i])    tag = "R5";
        else if (after_ack) tag = "R7";
        else                tag = "R2";
        chk(out_valid[i] == exp_v[i], tag, $sformatf("out_valid[%0d]", i),
            int'(out_valid[i]), int'(exp_v[i]));
        chk(out_data[i*DW +: DW] == in_data, "R3", $sformatf("out_data[%0d]", i),
            int'(out_data[i*DW +: DW]), int'(in_data));
      end
      hs      = exp_v & out_ready;
      exp_rdy = in_valid && ((got | hs) == '1);
      tag     = (got == '0 && hs == '1) ? "R6" : "R4";
      chk(in_ready == exp_rdy, tag, "in_ready", int'(in_ready), int'(exp_rdy));
      for (int i = 0; i < NO; i++) begin
        if (hs[i]) begin
          rx_cnt[i]++;
          // R9: exactly once per token
          chk(got[i] == 1'b0, "R9", $sformatf("duplicate on out %0d", i), 1, 0);
        end
      end
      if (exp_rdy) begin
        acked++;
        got     = '0;
        src_has = 1'b0;
      end else begin
        got = got | hs;
      end
      after_ack = exp_rdy;
      after_rst = 1'b0;
    end
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_data = '0; out_ready = '0;
    got = '0; src_has = 1'b0; cur = '0; acked = 0;
    after_ack = 1'b0; after_rst = 1'b0;
    for (int i = 0; i < NO; i++) rx_cnt[i] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // Idle first cycle: R8 with nothing offered.
    run_cycles(2, 0, 100);
    after_rst = 1'b1;
    // All outputs accept together: single-cycle acknowledge (R6).
    run_cycles(20, 0, 0);
    // Rotating single ready: staggered consumption (R5, R7).
    run_cycles(30, 1, 0);
    // Reset while a token is partially consumed (R1).
    @(negedge clk);
    in_valid = 1'b1; src_has = 1'b1; cur = 8'h5A; in_data = cur;
    out_ready = 3'b001;
    #1;
    chk(out_valid == 3'b111, "R1", "out_valid before partial take",
        int'(out_valid), 7);
    @(negedge clk);
    chk(out_valid == 3'b110, "R5", "out_valid after partial take",
        int'(out_valid), 6);
    rx_cnt[0]++;
    // Token restarts after reset; output 0 receives it again by design.
    rx_cnt[0]--;
    do_reset();
    run_cycles(40, 1, 0);
    // Random stalls with input gaps (R9).
    run_cycles(1500, 2, 30);
    run_cycles(1500, 3, 10);
    // Drain: all ready until the held token retires.
    run_cycles(5, 0, 100);
    for (int i = 0; i < NO; i++)
      chk(rx_cnt[i] == acked, "R9", $sformatf("tokens received on out %0d", i),
          rx_cnt[i], acked);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule